// File: doc/BRIEF.md
# SPI Serial Flash Target Emulator

This block behaves as a small serial flash memory on the device side of a mode-0 SPI bus. A bus master selects it with an active-low enable, clocks command bytes in MSB first, and receives data on a serial output. The output is driven only while the enable is low. The pins are sampled by the block's own system clock through two-stage synchronisers, so the serial clock must run well below that clock.

The storage is a register array of `2^ADDR_W` bytes. The block takes 24-bit addresses and keeps only their low `ADDR_W` bits. It decodes opcodes for read, status read and write, the write-enable latch, byte program, auto-increment program, three sizes of erase, and an identification read. Several pieces of state survive from one frame to the next: the latch, the auto-increment mode and its address, the arming needed before a status write, and a busy timer that stands in for cell program and erase time.

A command takes effect on the rising edge of the enable. It takes effect only if the frame ended on a byte boundary and carried exactly the number of bytes that the opcode needs.

Top module: `spi_flash_emu`

## Requirements
- R1: `miso_oe` is 0 and `miso` is released whenever `cs_n` is high. While `cs_n` is low, `miso_oe` is 1 and bits leave MSB first: a bit is sampled on the rising edge of `sck` and changes after the falling edge.
- R2: Opcode 0x03 is followed by a 24-bit address, high byte first. The block then returns the bytes at that address and at each following address for as long as `cs_n` stays low. Only the low `ADDR_W` address bits are used, so reading past the top of the array wraps to 0.
- R3: Status bit 0 is busy and bit 1 is the write-enable latch. A one-byte frame 0x06 sets the latch and a one-byte frame 0x04 clears it. Opcode 0x05 returns the status byte again at every byte boundary.
- R4: The frame 0x01 followed by one data byte copies data bits 7, 3 and 2 into status bits 7, 3 and 2, and leaves every other status bit alone. It does so only when the frame completed just before it was the one-byte frame 0x50. An accepted status write starts the busy timer.
- R5: Erase sets bytes to 0xFF. Opcode 0x20 with a 3-byte address erases the aligned `2^SECT_W`-byte region that holds the address. Opcode 0x52 with a 3-byte address erases the aligned `2^BLK_W`-byte region. The one-byte frame 0x60 erases the whole array.
- R6: Opcode 0x02 with a 3-byte address and one data byte stores the AND of the data byte and the old contents.
- R7: The frame 0xAF, 3 address bytes, data byte programs that address, enters auto-increment mode and keeps the latch set. While the mode is on, each frame 0xAF followed by one data byte programs the next address. A one-byte frame 0x04 leaves the mode.
- R8: Opcode 0x90 is followed by three bytes. Bit 0 of the third byte picks the next returned byte: 0 returns `MFR_ID` and 1 returns `DEV_ID`.
- R9: Program and erase take effect only while the latch is set. A completed byte program or erase clears the latch.
- R10: A program, an erase or a status write makes the busy bit read 1 for `BUSY_CYC` clock cycles. A frame that starts while the block is busy is ignored unless its opcode is 0x05. Such an ignored frame returns only zero bits.
- R11: A frame is discarded with no state change if `cs_n` rises in the middle of a byte, or if the frame's byte count does not match its opcode.
- R12: After reset the status byte is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all bus pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low device enable |
| sck | input | 1 | Serial clock from the bus master |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out; high impedance while `cs_n` is high |
| miso_oe | output | 1 | High while the block drives `miso` |

## Verification
Two things can happen on the same clock edge: the busy timer reaches zero, and a status stream reloads the status byte at a byte boundary. The bench provokes this by starting a chip erase and then reading status in a single long 0x05 frame that runs across the expiry. Each returned byte must equal the busy value with the latch already cleared. After that the stream must change to 0x00 once and never go back. A torn or mixed byte fails the check.

// File: rtl/spi_flash_emu.sv
module spi_flash_emu #(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 15,
  parameter int BUSY_CYC = 256,
  parameter logic [7:0] MFR_ID = 8'hA5,
  parameter logic [7:0] DEV_ID = 8'h3C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] BUSY_LD = CW'(BUSY_CYC);

  localparam logic [7:0] K_RD   = 8'h03;
  localparam logic [7:0] K_RDSR = 8'h05;
  localparam logic [7:0] K_WRSR = 8'h01;
  localparam logic [7:0] K_ARM  = 8'h50;
  localparam logic [7:0] K_WEN  = 8'h06;
  localparam logic [7:0] K_WDIS = 8'h04;
  localparam logic [7:0] K_PGM  = 8'h02;
  localparam logic [7:0] K_INC  = 8'hAF;
  localparam logic [7:0] K_SEC  = 8'h20;
  localparam logic [7:0] K_BLK  = 8'h52;
  localparam logic [7:0] K_ALL  = 8'h60;
  localparam logic [7:0] K_ID   = 8'h90;

  logic [2:0] sck_s, cs_s;
  logic [1:0] mo_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= 3'b111;
      mo_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      cs_s  <= {cs_s[1:0], cs_n};
      mo_s  <= {mo_s[0], mosi};
    end

  logic sck_up, sck_dn, sel, fin;
  assign sck_up = sck_s[1] & ~sck_s[2];
  assign sck_dn = ~sck_s[1] & sck_s[2];
  assign sel    = ~cs_s[1];
  assign fin    = cs_s[1] & ~cs_s[2];

  logic [7:0]  mem [DEPTH];
  logic [2:0]  bit_cnt, nb;
  logic [6:0]  sh;
  logic [7:0]  op, dat, out_sr, rx, status;
  logic [23:0] addr, a_now, aai_addr;
  logic        ign, wel, aai, arm, busy, done;
  logic [2:0]  prot;
  logic [CW-1:0] bcnt;

  assign busy    = bcnt != '0;
  assign status  = {prot[2], 3'b000, prot[1], prot[0], wel, busy};
  assign rx      = {sh, mo_s[1]};
  assign done    = sel & sck_up & (bit_cnt == 3'd7);
  assign a_now   = (nb <= 3'd3) ? {addr[15:0], rx} : addr;
  assign miso_oe = ~cs_n;
  assign miso    = miso_oe ? out_sr[7] : 1'bz;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; nb <= '0; sh <= '0; op <= '0; dat <= '0;
      out_sr <= '0; addr <= '0; ign <= 1'b0;
    end else if (!sel) begin
      bit_cnt <= '0; nb <= '0; out_sr <= '0; ign <= 1'b0;
    end else begin
      if (sck_up) begin
        bit_cnt <= bit_cnt + 3'd1;
        sh <= {sh[5:0], mo_s[1]};
      end
      if (sck_dn && bit_cnt != 3'd0) out_sr <= {out_sr[6:0], 1'b0};
      if (done) begin
        if (nb != 3'd7) nb <= nb + 3'd1;
        if (nb == 3'd0) begin
          op  <= rx;
          ign <= busy && (rx != K_RDSR);
          if (rx == K_RDSR) out_sr <= status;
        end else begin
          dat <= rx;
          if (nb <= 3'd3) addr <= a_now;
          if (!ign) begin
            if (op == K_RDSR) out_sr <= status;
            if (op == K_RD && nb >= 3'd3) begin
              out_sr <= mem[a_now[ADDR_W-1:0]];
              addr   <= a_now + 24'd1;
            end
            if (op == K_ID && nb == 3'd3) out_sr <= rx[0] ? DEV_ID : MFR_ID;
          end
        end
      end
    end

  logic commit, pg1, pg2, er_s, er_b, er_c, er, wsr;
  logic [ADDR_W-1:0] pa;
  int unsigned er_sh;
  assign commit = fin & (bit_cnt == 3'd0) & ~ign & (nb != 3'd0);
  assign pg1  = commit & wel & ~aai & (nb == 3'd5) & (op == K_PGM || op == K_INC);
  assign pg2  = commit & aai & (nb == 3'd2) & (op == K_INC);
  assign er_s = commit & wel & ~aai & (nb == 3'd4) & (op == K_SEC);
  assign er_b = commit & wel & ~aai & (nb == 3'd4) & (op == K_BLK);
  assign er_c = commit & wel & ~aai & (nb == 3'd1) & (op == K_ALL);
  assign er   = er_s | er_b | er_c;
  assign wsr  = commit & arm & (nb == 3'd2) & (op == K_WRSR);
  assign pa   = pg2 ? aai_addr[ADDR_W-1:0] : addr[ADDR_W-1:0];

  always_comb begin
    if (er_s)      er_sh = SECT_W;
    else if (er_b) er_sh = BLK_W;
    else           er_sh = ADDR_W;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (er && ((ADDR_W'(i) >> er_sh) == (addr[ADDR_W-1:0] >> er_sh)))
          mem[i] <= 8'hFF;
        else if ((pg1 | pg2) && ADDR_W'(i) == pa)
          mem[i] <= mem[i] & dat;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0; aai <= 1'b0; arm <= 1'b0;
      prot <= '0; bcnt <= '0; aai_addr <= '0;
    end else begin
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (commit) begin
        arm <= (op == K_ARM) && (nb == 3'd1);
        if (op == K_WEN && nb == 3'd1) wel <= 1'b1;
        if (op == K_WDIS && nb == 3'd1) begin
          wel <= 1'b0;
          aai <= 1'b0;
        end
        if (wsr) prot <= {dat[7], dat[3], dat[2]};
        if (pg1 && op == K_INC) begin
          aai <= 1'b1;
          aai_addr <= addr + 24'd1;
        end
        if (pg2) aai_addr <= aai_addr + 24'd1;
        if ((pg1 && op == K_PGM) || er) wel <= 1'b0;
        if (pg1 | pg2 | er | wsr) bcnt <= BUSY_LD;
      end
    end

  // R7
  aai_wel_chk: assert property (@(posedge clk) disable iff (!rst_n) aai |-> wel);
  // R4
  prot_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot) |-> $past(arm));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg1 | pg2 | er | wsr) |=> busy);
  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ign |-> (out_sr == 8'h00));
  // R9
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) er |=> !wel);
  // R11
  torn_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && bit_cnt != 3'd0) |=> ($stable(wel) && $stable(aai) && $stable(prot)));
endmodule

// File: tb/tb_spi_flash_emu.sv
module tb_spi_flash_emu;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  wire  miso, miso_oe;
  int checks = 0, errors = 0;
  logic [7:0] r, s, b0, b1;

  always #5 clk = ~clk;

  spi_flash_emu #(.ADDR_W(8), .SECT_W(4), .BLK_W(6), .BUSY_CYC(600),
                  .MFR_ID(8'hA5), .DEV_ID(8'h3C)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe));

  localparam logic [39:0] VEC [8] = '{
    {24'h000010, 8'h50, 8'hFF},
    {24'h00001F, 8'hFF, 8'h11},
    {24'h000021, 8'h22, 8'h33},
    {24'h000120, 8'h11, 8'h22},
    {24'h0000FF, 8'hFF, 8'hC3},
    {24'h000044, 8'hFF, 8'h77},
    {24'h00006F, 8'hFF, 8'h12},
    {24'h000084, 8'hFF, 8'h66}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rxb);
    rxb = '0;
    for (int b = 7; b > 7 - n; b--) begin
      mosi = tx[b];
      tick(4);
      rxb[b] = miso;
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rxb);
    xbits(tx, 8, rxb);
  endtask

  task automatic fbeg;
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic fend;
    tick(2);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic send1(input logic [7:0] op);
    logic [7:0] d;
    fbeg; xfer(op, d); fend;
  endtask

  task automatic send_a(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    xfer(op, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    fbeg; xfer(8'h05, d); xfer(8'h00, st); fend;
  endtask

  task automatic wait_idle;
    logic [7:0] st;
    for (int k = 0; k < 40; k++) begin
      rdsr(st);
      if (st[0] == 1'b0) break;
    end
  endtask

  task automatic read2(input logic [23:0] a, output logic [7:0] x0, output logic [7:0] x1);
    fbeg; send_a(8'h03, a); xfer(8'h00, x0); xfer(8'h00, x1); fend;
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] d);
    logic [7:0] q;
    send1(8'h06);
    fbeg; send_a(8'h02, a); xfer(d, q); fend;
    wait_idle;
  endtask

  task automatic two(input logic [7:0] op, input logic [7:0] d);
    logic [7:0] q;
    fbeg; xfer(op, q); xfer(d, q); fend;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk("R1 idle oe", {7'b0, miso_oe}, 8'h00);
    rdsr(s);            chk("R12 status", s, 8'h00);
    read2(24'h0, b0, b1); chk("R12 array", b0, 8'hFF); chk("R12 array", b1, 8'hFF);

    fbeg; send_a(8'h02, 24'h000010); xfer(8'h00, r); fend;
    rdsr(s);            chk("R9 no latch no busy", s, 8'h00);
    read2(24'h10, b0, b1); chk("R9 no latch no write", b0, 8'hFF);

    send1(8'h06); rdsr(s); chk("R3 latch set", s, 8'h02);
    send1(8'h04); rdsr(s); chk("R3 latch clear", s, 8'h00);

    send1(8'h06);
    fbeg; send_a(8'h02, 24'h000010); xfer(8'h5A, r); fend;
    rdsr(s);            chk("R10 busy R9 latch dropped", s, 8'h01);
    send1(8'h06);
    read2(24'h10, b0, b1); chk("R10 read ignored", b0, 8'h00); chk("R10 read ignored", b1, 8'h00);
    wait_idle;
    rdsr(s);            chk("R10 latch set ignored", s, 8'h00);
    read2(24'h10, b0, b1); chk("R6 program", b0, 8'h5A);

    prog(24'h10, 8'hF0);
    read2(24'h10, b0, b1); chk("R6 and", b0, 8'h50);
    prog(24'h00, 8'hC3); prog(24'h45, 8'h77); prog(24'h70, 8'h12); prog(24'h85, 8'h66);

    send1(8'h06);
    fbeg; send_a(8'hAF, 24'h000020); xfer(8'h11, r); fend;
    wait_idle;
    rdsr(s);            chk("R7 latch kept", s, 8'h02);
    two(8'hAF, 8'h22); wait_idle;
    two(8'hAF, 8'h33); wait_idle;
    send1(8'h04);
    rdsr(s);            chk("R7 mode ended", s, 8'h00);
    two(8'hAF, 8'h44);
    rdsr(s);            chk("R7 after end no busy", s, 8'h00);
    read2(24'h23, b0, b1); chk("R7 after end no write", b0, 8'hFF);

    for (int k = 0; k < 8; k++) begin
      read2(VEC[k][39:16], b0, b1);
      chk("R2 first", b0, VEC[k][15:8]);
      chk("R2 next", b1, VEC[k][7:0]);
    end

    fbeg; send_a(8'h90, 24'h000000); xfer(8'h00, r); fend; chk("R8 maker", r, 8'hA5);
    fbeg; send_a(8'h90, 24'h000001); xfer(8'h00, r); fend; chk("R8 device", r, 8'h3C);

    two(8'h01, 8'hFF);
    rdsr(s);            chk("R4 unarmed", s, 8'h00);
    send1(8'h50); two(8'h01, 8'hFF);
    rdsr(s);            chk("R4 busy", s, 8'h8D);
    wait_idle;
    rdsr(s);            chk("R4 masked", s, 8'h8C);
    send1(8'h50); send1(8'h06); two(8'h01, 8'h00);
    rdsr(s);            chk("R4 arm lost", s, 8'h8E);
    send1(8'h04); send1(8'h50); two(8'h01, 8'h00); wait_idle;
    rdsr(s);            chk("R4 restored", s, 8'h00);

    send1(8'h06);
    fbeg; send_a(8'h20, 24'h000040); xbits(8'h00, 4, r); fend;
    rdsr(s);            chk("R11 torn frame", s, 8'h02);
    read2(24'h44, b0, b1); chk("R11 torn data", b1, 8'h77);
    two(8'h60, 8'h00);
    rdsr(s);            chk("R11 extra byte", s, 8'h02);
    read2(24'hFF, b0, b1); chk("R11 extra byte data", b1, 8'hC3);

    fbeg; send_a(8'h20, 24'h00004A); fend;
    wait_idle;
    rdsr(s);            chk("R9 erase drops latch", s, 8'h00);
    read2(24'h44, b0, b1); chk("R5 sector", b1, 8'hFF);
    read2(24'h6F, b0, b1); chk("R5 sector edge", b1, 8'h12);
    read2(24'h0F, b0, b1); chk("R5 other sector", b1, 8'h50);
    send1(8'h06);
    fbeg; send_a(8'h52, 24'h00007F); fend;
    wait_idle;
    read2(24'h6F, b0, b1); chk("R5 block", b1, 8'hFF);
    read2(24'h84, b0, b1); chk("R5 next block", b1, 8'h66);
    read2(24'h1F, b0, b1); chk("R5 lower block", b1, 8'h11);

    send1(8'h06); send1(8'h60);
    begin
      logic seen_clear;
      int bad;
      seen_clear = 1'b0;
      bad = 0;
      fbeg;
      chk("R1 driving", {7'b0, miso_oe}, 8'h01);
      xfer(8'h05, r);
      xfer(8'h00, s);
      chk("R10 poll start", s, 8'h01);
      for (int k = 0; k < 30; k++) begin
        xfer(8'h00, s);
        if (s == 8'h00) seen_clear = 1'b1;
        else if (s != 8'h01 || seen_clear) bad++;
        if (seen_clear) break;
      end
      fend;
      chk("R10 poll clean", 8'(bad), 8'h00);
      chk("R3 poll ends idle", {7'b0, seen_clear}, 8'h01);
    end
    chk("R1 released", {7'b0, miso_oe}, 8'h00);
    read2(24'h00, b0, b1); chk("R5 chip", b0, 8'hFF);
    read2(24'h84, b0, b1); chk("R5 chip", b1, 8'hFF);

    finish_run;
  end
endmodule